// File: doc/BRIEF.md
# ARINC 429 Serial Word Transmitter

This block serialises 32-bit avionics data words onto a pair of complementary return-to-zero logic outputs, `out_a` and `out_b`, for an external line driver. A host builds each word from two 16-bit halves. A first load strobe holds the low half, and a second load strobe joins it with the high half and pushes the full word into a small transmit FIFO. While the enable input is high, the transmitter takes words from the FIFO, sends each one least significant bit first, and leaves a null gap of several bit times between words.

All timing comes from one master clock. One bit lasts `HI_DIV` clocks in the fast mode and `LO_DIV` clocks in the slow mode; with a 1 MHz clock these give 100 kbps and 12.5 kbps. A free-running bit clock output is high for the first half of every bit period. A ready flag shows that the FIFO is empty.

A two-bit control register sets the rate and a parity enable. A force pin can turn parity on whatever that bit holds. An active-low master reset clears the transmit path and keeps the control register.

Top module: `a429_tx`

## Requirements
- R1: A 1 bit drives `out_a` high and `out_b` low for the first half of its bit period (`HI_DIV/2` or `LO_DIV/2` clocks). A 0 bit drives `out_b` high and `out_a` low for the first half. Both outputs are low in the second half, and they are never high together.
- R2: A falling edge of `ld_cfg_n` loads the control register. `din[0]` selects the slow rate when 1, and `din[4]` is the parity enable. Consecutive bits of a word start `HI_DIV` clocks apart in the fast mode and `LO_DIV` clocks apart in the slow mode.
- R3: `bit_clk` toggles continuously. It is high for the first half and low for the second half of each bit period, and it rises in the same clock as the leading edge of each data pulse.
- R4: A falling edge of `ld_lo_n` latches `din` as word bits 15:0. A falling edge of `ld_hi_n` pushes the word with `din` as bits 31:16. Words leave in FIFO order, bit 0 first.
- R5: `tx_ready` is high exactly when the FIFO holds no word.
- R6: A new word starts only while `tx_en` is high. A falling edge of `tx_en` empties the FIFO, and a word already on the line finishes.
- R7: When `par_force` is 1 or control bit 4 is 1, bit 31 of the sent word is replaced so that the 32 bits hold an odd number of ones. Otherwise bit 31 is sent as written.
- R8: While `rst_n` is low, the FIFO, the bit position, the gap timer and the rate divider are cleared, and `tx_ready` is high. The control register keeps its value.
- R9: Between words both outputs stay low for at least `GAP_BITS` bit periods. When the next word is already waiting, the gap is exactly `GAP_BITS` bit periods, so word starts are `(32+GAP_BITS)` bit periods apart.
- R10: The FIFO holds `DEPTH` words. A push while it is full is ignored and leaves the stored words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Master reset, active low |
| din | input | 16 | Host data for word halves and control |
| ld_lo_n | input | 1 | Load strobe for word bits 15:0, active low |
| ld_hi_n | input | 1 | Load strobe for word bits 31:16 and push, active low |
| ld_cfg_n | input | 1 | Control register load strobe, active low |
| tx_en | input | 1 | Transmit enable; its falling edge clears the FIFO |
| par_force | input | 1 | Forces parity insertion when high |
| out_a | output | 1 | Return-to-zero output, pulses for 1 bits |
| out_b | output | 1 | Return-to-zero output, pulses for 0 bits |
| bit_clk | output | 1 | Bit-rate clock, high during the first half of each bit |
| tx_ready | output | 1 | High when the FIFO is empty |

## Verification
The bench builds the block with `HI_DIV=4`, `LO_DIV=8`, `DEPTH=4` and `GAP_BITS=4`. These short divisors let it send many words in both rate modes, and it checks every pulse width and bit spacing against the rate it selected. A four-entry FIFO fills after a few pushes, so the bench can test the ignored fifth push and the exact back-to-back gap. It also checks the enable-fall clear and a reset that keeps the control register.

// File: rtl/a429_tx.sv
module a429_tx #(
  parameter int HI_DIV   = 10,
  parameter int LO_DIV   = 80,
  parameter int DEPTH    = 8,
  parameter int GAP_BITS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] din,
  input  logic        ld_lo_n,
  input  logic        ld_hi_n,
  input  logic        ld_cfg_n,
  input  logic        tx_en,
  input  logic        par_force,
  output logic        out_a,
  output logic        out_b,
  output logic        bit_clk,
  output logic        tx_ready
);
  localparam int DW = $clog2(LO_DIV + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int GW = $clog2(GAP_BITS + 1);

  typedef enum logic [1:0] {IDLE, SEND, GAP} st_t;

  logic [1:0]    cfg = 2'b00;   // {parity enable, slow rate}
  logic          lo_q, hi_q, cfg_q, en_q;
  logic [15:0]   lo_half;
  logic [31:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] count;
  logic [DW-1:0] div_cnt;
  logic [GW-1:0] gap_cnt;
  logic [4:0]    bit_n;
  logic [31:0]   sh;
  st_t           st;

  wire lo_stb  = lo_q & ~ld_lo_n;
  wire hi_stb  = hi_q & ~ld_hi_n;
  wire cfg_stb = cfg_q & ~ld_cfg_n;
  wire clr     = en_q & ~tx_en;

  wire [DW-1:0] lim  = cfg[0] ? DW'(LO_DIV - 1) : DW'(HI_DIV - 1);
  wire [DW-1:0] half = cfg[0] ? DW'(LO_DIV / 2) : DW'(HI_DIV / 2);
  wire tick = div_cnt >= lim;

  wire full  = count == CW'(DEPTH);
  wire push  = hi_stb && !full && !clr;
  wire start = tick && tx_en && !clr && count != '0 &&
               (st == IDLE || (st == GAP && gap_cnt == '0));

  wire [31:0] head    = mem[rp];
  wire        par_on  = par_force | cfg[1];
  wire [31:0] tx_word = par_on ? {~^head[30:0], head[30:0]} : head;

  assign bit_clk  = div_cnt < half;
  assign out_a    = (st == SEND) &  sh[0] & bit_clk;
  assign out_b    = (st == SEND) & ~sh[0] & bit_clk;
  assign tx_ready = count == '0;

  always_ff @(posedge clk)
    if (cfg_stb) cfg <= {din[4], din[0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lo_q <= 1'b1; hi_q <= 1'b1; cfg_q <= 1'b1; en_q <= 1'b0;
      lo_half <= '0;
    end else begin
      lo_q <= ld_lo_n; hi_q <= ld_hi_n; cfg_q <= ld_cfg_n; en_q <= tx_en;
      if (lo_stb) lo_half <= din;
    end

  always_ff @(posedge clk)
    if (push) mem[wp] <= {din, lo_half};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (push)  wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (start) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      count <= count + CW'(push) - CW'(start);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_cnt <= '0; st <= IDLE; bit_n <= '0; gap_cnt <= '0; sh <= '0;
    end else begin
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
      if (start) begin
        st <= SEND; sh <= tx_word; bit_n <= '0;
      end else if (tick) begin
        case (st)
          SEND: if (bit_n == 5'd31) begin
                  st <= GAP; gap_cnt <= GW'(GAP_BITS - 1);
                end else begin
                  bit_n <= bit_n + 1'b1; sh <= sh >> 1;
                end
          GAP:  if (gap_cnt == '0) st <= IDLE;
                else gap_cnt <= gap_cnt - 1'b1;
          default: ;
        endcase
      end
    end

  a_r1_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_a && out_b));
  a_r1_rz_second_half: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_clk |-> !out_a && !out_b);
  a_r9_gap_null: assert property (@(posedge clk) disable iff (!rst_n)
    st == GAP |-> !out_a && !out_b);
  a_r5_push_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    hi_stb && !clr |=> !tx_ready);
  a_r6_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_en) |=> tx_ready);
  a_r10_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    full && hi_stb && !start && !clr |=> full);
endmodule

// File: tb/a429_tx_tb_top.sv
module a429_tx_tb_top;
  localparam int HI = 4, LO = 8, DEP = 4, GAPB = 4;

  logic clk = 0, rst_n = 0;
  logic [15:0] din = '0;
  logic ld_lo_n = 1, ld_hi_n = 1, ld_cfg_n = 1, tx_en = 0, par_force = 0;
  logic out_a, out_b, bit_clk, tx_ready;

  a429_tx #(.HI_DIV(HI), .LO_DIV(LO), .DEPTH(DEP), .GAP_BITS(GAPB)) dut_i (
    .clk, .rst_n, .din, .ld_lo_n, .ld_hi_n, .ld_cfg_n, .tx_en, .par_force,
    .out_a, .out_b, .bit_clk, .tx_ready);

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  logic [31:0] exp_q [$];
  int cur_div = HI;
  bit cfg_par = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor
  bit prev_act = 0;
  int hi_cnt = 0, bitn = 0, words_rx = 0, pulses = 0;
  longint cyc = 0, last_bit_start = 0, word_start = 0, last_spacing = 0;
  logic [31:0] shreg;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      prev_act = 0; hi_cnt = 0; bitn = 0;
    end else begin
      if (out_a && out_b) chk(0, "R1 both outputs high", 1, 0);
      if ((out_a | out_b) && !prev_act) begin
        pulses++;
        chk(bit_clk == 1, "R3 bit_clk phase at bit start", bit_clk, 1);
        if (bitn > 0)
          chk(cyc - last_bit_start == cur_div, "R2 bit spacing", cyc - last_bit_start, cur_div);
        else begin
          if (words_rx > 0) last_spacing = cyc - word_start;
          word_start = cyc;
        end
        shreg[bitn] = out_a;
        last_bit_start = cyc;
        hi_cnt = 1;
      end else if (out_a | out_b) hi_cnt++;
      if (!(out_a | out_b) && prev_act) begin
        chk(hi_cnt == cur_div / 2, "R1 pulse width", hi_cnt, cur_div / 2);
        bitn++;
        if (bitn == 32) begin
          bitn = 0;
          words_rx++;
          if (exp_q.size() == 0) chk(0, "R4 unexpected word", shreg, 0);
          else begin
            logic [31:0] e;
            e = exp_q.pop_front();
            chk(shreg == e, "R4/R7 word content", shreg, e);
          end
        end
      end
      prev_act = out_a | out_b;
    end
  end

  task automatic strobe(input int which, input logic [15:0] v);
    @(negedge clk);
    din = v;
    if (which == 0) ld_lo_n = 0; else if (which == 1) ld_hi_n = 0; else ld_cfg_n = 0;
    @(negedge clk);
    ld_lo_n = 1; ld_hi_n = 1; ld_cfg_n = 1;
    @(negedge clk);
  endtask

  task automatic set_cfg(input bit slow, input bit par);
    strobe(2, {11'd0, par, 3'd0, slow});
    cur_div = slow ? LO : HI;
    cfg_par = par;
  endtask

  task automatic send_word(input logic [31:0] w, input bit expect_tx);
    strobe(0, w[15:0]);
    strobe(1, w[31:16]);
    if (expect_tx) begin
      if (par_force || cfg_par) exp_q.push_back({~^w[30:0], w[30:0]});
      else exp_q.push_back(w);
    end
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat ((GAPB + 2) * LO) @(negedge clk);
  endtask

  task automatic measure_bclk(input string tag);
    int h, l;
    h = 0; l = 0;
    while (bit_clk != 0) @(negedge clk);
    while (bit_clk != 1) @(negedge clk);
    while (bit_clk == 1) begin h++; @(negedge clk); end
    while (bit_clk == 0) begin l++; @(negedge clk); end
    chk(h == cur_div / 2, {tag, " high time"}, h, cur_div / 2);
    chk(l == cur_div / 2, {tag, " low time"}, l, cur_div / 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base;
    set_cfg(0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(tx_ready == 1, "R8 ready after reset", tx_ready, 1);
    chk(out_a == 0 && out_b == 0, "R8 outputs idle after reset", {out_a, out_b}, 0);

    measure_bclk("R3 fast");

    // R5: ready drops on push with enable low, nothing transmitted (R6)
    base = pulses;
    send_word(32'h1234_5678, 1);
    chk(tx_ready == 0, "R5 not ready with word stored", tx_ready, 0);
    repeat (10 * HI) @(negedge clk);
    chk(pulses == base, "R6 no output while disabled", pulses, base);
    tx_en = 1;
    drain();
    chk(tx_ready == 1, "R5 ready after drain", tx_ready, 1);

    // several patterns, back-to-back gap (R9)
    tx_en = 0;
    @(negedge clk);
    send_word(32'hFFFF_FFFF, 1);
    send_word(32'h0000_0000, 1);
    send_word(32'hA5C3_0F81, 1);
    tx_en = 1;
    drain();
    chk(last_spacing == (32 + GAPB) * HI, "R9 back-to-back gap", last_spacing, (32 + GAPB) * HI);

    // parity forced by pin (R7)
    par_force = 1;
    send_word(32'h0000_0000, 1);
    send_word(32'h0000_0001, 1);
    drain();
    par_force = 0;

    // parity by control bit 4, slow rate (R2, R7)
    tx_en = 0;
    set_cfg(1, 1);
    tx_en = 1;
    measure_bclk("R3 slow");
    send_word(32'h7FFF_FFFE, 1);
    send_word(32'h8000_0003, 1);
    drain();

    // reset keeps control register and clears FIFO (R8)
    tx_en = 0;
    @(negedge clk);
    send_word(32'h1111_2222, 0);
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(tx_ready == 1, "R8 FIFO cleared by reset", tx_ready, 1);
    rst_n = 1;
    base = words_rx;
    tx_en = 1;
    repeat ((32 + GAPB) * LO) @(negedge clk);
    chk(words_rx == base, "R8 no stale word after reset", words_rx, base);
    send_word(32'h0F0F_0F0E, 1);  // slow timing and parity kept
    drain();

    // enable fall clears FIFO, in-flight word completes (R6)
    tx_en = 0;
    set_cfg(0, 0);
    send_word(32'hCAFE_0001, 1);
    send_word(32'hCAFE_0002, 0);
    send_word(32'hCAFE_0003, 0);
    base = words_rx;
    tx_en = 1;
    while (!(out_a | out_b)) @(negedge clk);
    tx_en = 0;
    repeat (2) @(negedge clk);
    chk(tx_ready == 1, "R6 enable fall clears FIFO", tx_ready, 1);
    tx_en = 1;
    drain();
    repeat (3 * (32 + GAPB) * HI) @(negedge clk);
    chk(words_rx == base + 1, "R6 only in-flight word sent", words_rx, base + 1);

    // full FIFO ignores extra push (R10)
    tx_en = 0;
    @(negedge clk);
    for (int i = 0; i < DEP; i++) send_word(32'h5000_0000 + i, 1);
    send_word(32'hDEAD_BEEF, 0);
    base = words_rx;
    tx_en = 1;
    drain();
    repeat (2 * (32 + GAPB) * HI) @(negedge clk);
    chk(words_rx == base + DEP, "R10 extra push ignored", words_rx, base + DEP);
    chk(exp_q.size() == 0, "R4 all expected words seen", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule